// File: doc/BRIEF.md
# Pixel Hit Counter Chain with Serial Readout

A column of pixel cells, each holding a binary counter that records how many times its discriminator fired. While the column is in count mode, every pixel counts independently, one step per rising edge of its own, already synchronized, discriminator pulse. The counter holds at its top value once it gets there.

When the mode input selects shift mode, counting stops and each counter's flip-flops become stages of one long shift register that runs through every cell. Cell 0 takes its bit from the serial input. Every later cell takes the top bit of the cell before it. The top bit of the last cell drives the serial output. Clocking the chain CNT_W × NUM_PIX times with the shift enable raised brings every pixel's count out on the single output line, with no separate readout bus. A synchronous clear zeroes every counter in either mode.

Top module: `pxc_chain`

## Requirements
- R1: After reset every counter is zero and `ser_o` is 0.
- R2: In count mode (`shift_mode_i`=0), each 0-to-1 transition of a pixel's `disc_i` bit between consecutive clock cycles adds exactly one to that pixel's counter. A pulse held high for many cycles counts once. Other pixels are unaffected.
- R3: A counter that reaches 2^CNT_W−1 stays there on further pulses and does not wrap.
- R4: While `shift_mode_i`=1, no counter increments. Rising edges that start and end in shift mode are lost.
- R5: With `shift_mode_i`=1 and `shift_en_i`=1, each cell shifts its counter one place toward the MSB. Cell k's LSB takes the MSB of cell k−1, and cell 0's LSB takes `ser_i`. `ser_o` is the MSB of cell NUM_PIX−1. Bits therefore leave MSB first, starting with the last cell.
- R6: With `shift_mode_i`=1 and `shift_en_i`=0, all counters hold. `shift_en_i` has no effect in count mode.
- R7: `clr_i`=1 zeroes every counter at the next clock edge in either mode. It takes priority over counting and shifting.
- R8: A complete readout takes exactly CNT_W × NUM_PIX shifts. Afterwards the chain holds the bits fed on `ser_i`, and the first bit fed sits at the MSB of the last cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disc_i | input | NUM_PIX | Synchronized discriminator level, one bit per pixel |
| shift_mode_i | input | 1 | 0 = count mode, 1 = shift mode |
| shift_en_i | input | 1 | Shift step enable, used only in shift mode |
| clr_i | input | 1 | Synchronous clear of all counters |
| ser_i | input | 1 | Serial input into cell 0 |
| ser_o | output | 1 | Serial output from the last cell |

## Verification
The bench builds the chain with NUM_PIX=4 and CNT_W=5. This makes a full readout only 20 shifts long and puts saturation at 31, so it takes a few dozen pulses to reach. The vector table drives per-pixel pulse counts below, at and above saturation, then decodes each pixel from the serial stream. Directed tests cover held pulses, pulses lost in shift mode, stray shift enables in count mode, clear priority, and a loopback that feeds a known pattern in and reads it back out.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_COUNT = 2'd2,
    OP_SHIFT = 2'd3
  } cell_op_e;
endpackage

// File: rtl/pxc_edge.sv
module pxc_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R2: a rising edge is reported for one cycle only
  p_single_rise_r2: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pxc_cell.sv
module pxc_cell #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic hit_i,
  input  logic shift_mode_i,
  input  logic shift_en_i,
  input  logic ser_i,
  output logic ser_o
);
  import pxc_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  cell_op_e         op;

  always_comb begin
    if (clr_i)             op = OP_CLEAR;
    else if (shift_mode_i) op = shift_en_i ? OP_SHIFT : OP_HOLD;
    else if (hit_i && cnt_q != CNT_MAX) op = OP_COUNT;
    else                   op = OP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case (op)
        OP_CLEAR: cnt_q <= '0;
        OP_COUNT: cnt_q <= cnt_q + 1'b1;
        OP_SHIFT: cnt_q <= {cnt_q[CNT_W-2:0], ser_i};
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign ser_o = cnt_q[CNT_W-1];

  // R2: in count mode the counter moves by at most one per cycle
  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    (!shift_mode_i && !clr_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  // R3: a full counter stays full while counting
  p_sat_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!shift_mode_i && !clr_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R4, R6: shift mode without enable freezes the counter
  p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (shift_mode_i && !shift_en_i && !clr_i) |=> $stable(cnt_q));
  // R5: a shift step loads the upstream bit into the LSB
  p_shift_lsb_r5: assert property (@(posedge clk) disable iff (rst)
    (shift_mode_i && shift_en_i && !clr_i) |=> cnt_q[0] == $past(ser_i));
  // R7: clear empties the counter
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/pxc_chain.sv
module pxc_chain #(
  parameter int NUM_PIX = 64,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_PIX-1:0] disc_i,
  input  logic               shift_mode_i,
  input  logic               shift_en_i,
  input  logic               clr_i,
  input  logic               ser_i,
  output logic               ser_o
);
  logic [NUM_PIX:0]   link;
  logic [NUM_PIX-1:0] rise;

  assign link[0] = ser_i;

  for (genvar g = 0; g < NUM_PIX; g++) begin : g_pix
    pxc_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .lvl_i  (disc_i[g]),
      .rise_o (rise[g])
    );
    pxc_cell #(.CNT_W(CNT_W)) u_cell (
      .clk          (clk),
      .rst          (rst),
      .clr_i        (clr_i),
      .hit_i        (rise[g]),
      .shift_mode_i (shift_mode_i),
      .shift_en_i   (shift_en_i),
      .ser_i        (link[g]),
      .ser_o        (link[g+1])
    );
  end

  assign ser_o = link[NUM_PIX];

  // R5: the output only changes on a shift step, a clear or a count
  p_out_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (shift_mode_i && !shift_en_i && !clr_i) |=> $stable(ser_o));
endmodule

// File: tb/pxc_chain_bench.sv
`timescale 1ns/1ps
module pxc_chain_bench;
  localparam int NP  = 4;
  localparam int CW  = 5;
  localparam int TOT = NP * CW;
  localparam int MAXV = (1 << CW) - 1;
  localparam int NV  = 6;
  localparam int VEC [NV][NP] = '{
    '{0, 1, 2, 3},
    '{5, 0, 7, 31},
    '{33, 12, 0, 4},
    '{1, 1, 1, 1},
    '{16, 8, 4, 2},
    '{30, 31, 32, 0}
  };

  logic clk = 0, rst = 1, shift_mode = 0, shift_en = 0, clr = 0, ser_in = 0;
  logic [NP-1:0] disc = '0;
  logic ser_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [TOT-1:0] stream;
  int cnt [NP];

  always #2 clk = ~clk;

  pxc_chain #(.NUM_PIX(NP), .CNT_W(CW)) u_pxc_chain (
    .clk(clk), .rst(rst), .disc_i(disc), .shift_mode_i(shift_mode),
    .shift_en_i(shift_en), .clr_i(clr), .ser_i(ser_in), .ser_o(ser_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reads TOT bits out (R5, R8), feeding feed[j] on shift j
  task automatic read_chain(input logic [TOT-1:0] feed);
    for (int j = 0; j < TOT; j++) begin
      @(negedge clk);
      stream[j] = ser_out;
      shift_mode = 1; shift_en = 1; ser_in = feed[j];
    end
    @(negedge clk);
    shift_en = 0; shift_mode = 0; ser_in = 0;
    for (int p = 0; p < NP; p++) begin
      cnt[p] = 0;
      for (int b = 0; b < CW; b++)
        cnt[p][b] = stream[(NP-1-p)*CW + (CW-1-b)];
    end
  endtask

  task automatic pulse(input logic [NP-1:0] m);
    @(negedge clk); disc = m;
    @(negedge clk); disc = '0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic load(input int v [NP]);
    for (int k = 0; k < 40; k++) begin
      logic [NP-1:0] m;
      for (int p = 0; p < NP; p++) m[p] = (v[p] > k);
      if (m != '0) pulse(m);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 ser_o after reset", ser_out, 0);
    read_chain('0);
    for (int p = 0; p < NP; p++) check("R1 counter after reset", cnt[p], 0);

    // vector table: R2, R3, R5
    for (int v = 0; v < NV; v++) begin
      int vv [NP];
      clear_all();
      for (int p = 0; p < NP; p++) vv[p] = VEC[v][p];
      load(vv);
      read_chain('0);
      for (int p = 0; p < NP; p++)
        check("R2/R3 table count", cnt[p], (vv[p] > MAXV) ? MAXV : vv[p]);
    end

    // R2: held pulse counts once
    clear_all();
    @(negedge clk); disc = 4'b0010;
    repeat (10) @(negedge clk);
    disc = '0;
    read_chain('0);
    check("R2 held pulse", cnt[1], 1);
    check("R2 other pixel", cnt[0], 0);

    // R3: well past saturation
    clear_all();
    for (int k = 0; k < 45; k++) pulse(4'b1000);
    read_chain('0);
    check("R3 saturation", cnt[3], MAXV);

    // R4, R6: pulses in shift mode lost, counts held
    clear_all();
    load('{3, 0, 0, 2});
    @(negedge clk); shift_mode = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); disc = 4'b1111;
      @(negedge clk); disc = '0;
    end
    @(negedge clk); shift_mode = 0;
    read_chain('0);
    check("R4 no count in shift mode", cnt[1], 0);
    check("R6 hold in shift mode", cnt[0], 3);
    check("R6 hold in shift mode", cnt[3], 2);

    // R6: shift enable ignored in count mode
    clear_all();
    load('{6, 9, 0, 1});
    @(negedge clk); shift_en = 1; ser_in = 1;
    repeat (3) @(negedge clk);
    shift_en = 0; ser_in = 0;
    read_chain('0);
    check("R6 shift_en in count mode", cnt[0], 6);
    check("R6 shift_en in count mode", cnt[1], 9);
    check("R6 shift_en in count mode", cnt[2], 0);

    // R7: clear in shift mode, and clear beats a coincident rise
    load('{4, 4, 4, 4});
    @(negedge clk); shift_mode = 1; clr = 1;
    @(negedge clk); clr = 0; shift_mode = 0;
    read_chain('0);
    check("R7 clear in shift mode", cnt[2], 0);
    load('{2, 0, 0, 0});
    @(negedge clk); disc = 4'b0001; clr = 1;
    @(negedge clk); disc = '0; clr = 0;
    read_chain('0);
    check("R7 clear over count", cnt[0], 0);

    // R8: loopback of a fed pattern in exactly TOT shifts
    read_chain(20'hA5C3B);
    read_chain('0);
    check("R8 loopback stream", int'(stream), int'(20'hA5C3B));
    check("R8 pixel3 after load", cnt[3], 5'b11011);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule